// File: doc/BRIEF.md
# Dual-Mode PAM Level Encoder

This block turns a stream of three-bit symbols into the two abstract drive codes that a two-mode line driver needs: a common-mode level index (low, middle or high) and a signed differential level code. Together the two codes carry eight distinct symbol states, the same capacity as eight-level amplitude signalling. Only five differential values are ever used, counting zero.

The modulator supplies a pulse-width signal `pwm` that goes high once per symbol. A symbol is taken on the rising edge of `pwm` as the block sees it in its own clock domain. The common-mode index then holds for the whole symbol and beyond. The differential code is driven only while `pwm` stays high, and is zero while `pwm` is low.

Symbols enter over a valid/ready pair. `sym_ready` is high for exactly one cycle per `pwm` rising edge. A transfer happens when `sym_valid` and `sym_ready` are both high in the same cycle. A producer under back-pressure keeps `sym_valid` and `sym_data` steady until it sees the transfer. If no symbol is offered at a rising edge, that symbol is sent as idle.

Top module: `pam_dual_mode_enc`

## Requirements
- R1: While `rst_n` is low, and after its release until the first transfer, `cm_lvl` is 1 (middle), `dm_code` is 0 and `sym_ready` is low.
- R2: `sym_ready` is high in exactly the cycles where `pwm` is 1 and `pwm` was 0 in the previous clock cycle. A transfer is `sym_valid && sym_ready`.
- R3: On a transfer, the next cycle shows the mapped pair (`cm_lvl`: 2 = high, 1 = middle, 0 = low; `dm_code`: 3-bit two's complement). The mapping is 000→(2,-1), 001→(2,+1), 011→(1,-2), 010→(1,-1), 110→(1,+1), 111→(1,+2), 101→(0,-2), 100→(0,+2). This order is Gray-coded, so neighbouring states differ in one data bit.
- R4: After a transfer, `dm_code` keeps the mapped value for every cycle in which `pwm` stays high.
- R5: In the cycle after `pwm` is sampled 0, `dm_code` is 0. `cm_lvl` keeps its value through the low phase.
- R6: `cm_lvl` changes only in the cycle after a transfer, so it changes at most once per symbol.
- R7: A `pwm` rising edge with `sym_valid` low sends an idle symbol. `dm_code` is 0 for that whole symbol and `cm_lvl` keeps its previous value.
- R8: `dm_code` only takes the values -2, -1, 0, +1 and +2. With the high common level it is never ±2, and with the low common level it is never ±1.
- R9: Changes on `sym_data` or `sym_valid` outside a transfer cycle have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm | input | 1 | Pulse-width symbol signal from the modulator, synchronous to `clk` |
| sym_valid | input | 1 | Symbol offered |
| sym_ready | output | 1 | Symbol accepted this cycle (one pulse per `pwm` rise) |
| sym_data | input | 3 | Three data bits of the symbol |
| cm_lvl | output | 2 | Common-mode level index: 0 low, 1 middle, 2 high |
| dm_code | output | 3 | Signed differential level code |

## Verification
The bench sweeps all eight codes so that a wrong entry in the Gray table shows up as a wrong level pair. It sends one-cycle high and low phases to catch a design that drops or delays the edge detection. It offers rising edges with no valid symbol. A design that reuses the last symbol there would drive a non-zero differential code, or move the common level. It also changes the data mid-symbol, which exposes a design that samples data outside the transfer cycle.

// File: rtl/pam_enc_pkg.sv
package pam_enc_pkg;
  localparam int SYM_BITS = 3;
  localparam int DM_W     = 3;
  localparam int CM_W     = 2;

  typedef enum logic [CM_W-1:0] {
    CM_LOW  = 2'd0,
    CM_MID  = 2'd1,
    CM_HIGH = 2'd2
  } cm_lvl_e;

  typedef struct packed {
    cm_lvl_e                 cm;
    logic signed [DM_W-1:0]  dm;
  } lvl_pair_t;

  // Position along the Gray-ordered state line -> level pair.
  function automatic lvl_pair_t pos_to_pair(input logic [SYM_BITS-1:0] pos);
    lvl_pair_t p;
    case (pos)
      3'd0:    begin p.cm = CM_HIGH; p.dm = -3'sd1; end
      3'd1:    begin p.cm = CM_HIGH; p.dm =  3'sd1; end
      3'd2:    begin p.cm = CM_MID;  p.dm = -3'sd2; end
      3'd3:    begin p.cm = CM_MID;  p.dm = -3'sd1; end
      3'd4:    begin p.cm = CM_MID;  p.dm =  3'sd1; end
      3'd5:    begin p.cm = CM_MID;  p.dm =  3'sd2; end
      3'd6:    begin p.cm = CM_LOW;  p.dm = -3'sd2; end
      default: begin p.cm = CM_LOW;  p.dm =  3'sd2; end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/pam_pwm_edge.sv
module pam_pwm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm,
  output logic rise,
  output logic low_now
);
  logic pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm;
  end

  assign rise    = pwm & ~pwm_q;
  assign low_now = ~pwm;
endmodule

// File: rtl/pam_sym_map.sv
module pam_sym_map
  import pam_enc_pkg::*;
#(
  parameter int N = SYM_BITS
) (
  input  logic [N-1:0] data,
  output lvl_pair_t    pair
);
  logic [N-1:0] pos;

  assign pos[N-1] = data[N-1];
  generate
    for (genvar i = N - 2; i >= 0; i--) begin : g_g2b
      assign pos[i] = pos[i+1] ^ data[i];
    end
  endgenerate

  assign pair = pos_to_pair(pos);
endmodule

// File: rtl/pam_level_hold.sv
module pam_level_hold
  import pam_enc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   take,
  input  logic                   idle,
  input  logic                   clear_dm,
  input  lvl_pair_t              nxt,
  output cm_lvl_e                cm,
  output logic signed [DM_W-1:0] dm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cm <= CM_MID;
      dm <= '0;
    end else if (take) begin
      cm <= nxt.cm;
      dm <= nxt.dm;
    end else if (idle || clear_dm) begin
      dm <= '0;
    end
  end
endmodule

// File: rtl/pam_dual_mode_enc.sv
module pam_dual_mode_enc
  import pam_enc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwm,
  input  logic                sym_valid,
  output logic                sym_ready,
  input  logic [SYM_BITS-1:0] sym_data,
  output logic [CM_W-1:0]     cm_lvl,
  output logic [DM_W-1:0]     dm_code
);
  logic                   rise, low_now;
  lvl_pair_t              mapped;
  cm_lvl_e                cm_q;
  logic signed [DM_W-1:0] dm_q;

  pam_pwm_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm     (pwm),
    .rise    (rise),
    .low_now (low_now)
  );

  pam_sym_map #(.N(SYM_BITS)) u_map (
    .data (sym_data),
    .pair (mapped)
  );

  pam_level_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (rise & sym_valid),
    .idle     (rise & ~sym_valid),
    .clear_dm (low_now),
    .nxt      (mapped),
    .cm       (cm_q),
    .dm       (dm_q)
  );

  assign sym_ready = rise;
  assign cm_lvl    = cm_q;
  assign dm_code   = dm_q;
endmodule

// File: rtl/pam_dual_mode_enc_chk.sv
module pam_dual_mode_enc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm,
  input logic       sym_valid,
  input logic       sym_ready,
  input logic [1:0] cm_lvl,
  input logic [2:0] dm_code
);
  assert_dm_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm |=> (dm_code == 3'd0));

  assert_cm_only_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sym_valid && sym_ready) |=> $stable(cm_lvl));

  assert_dm_held_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !sym_ready) |=> $stable(dm_code));

  assert_take_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (dm_code != 3'd0));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_ready && !sym_valid) |=> (dm_code == 3'd0));

  assert_ready_needs_pwm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready |-> pwm);

  assert_legal_dm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_code != 3'b011) && (dm_code != 3'b100) && (dm_code != 3'b101) && (cm_lvl != 2'd3));

  assert_high_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_lvl == 2'd2) |-> (dm_code == 3'd0 || dm_code == 3'b001 || dm_code == 3'b111));

  assert_low_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_lvl == 2'd0) |-> (dm_code == 3'd0 || dm_code == 3'b010 || dm_code == 3'b110));
endmodule

bind pam_dual_mode_enc pam_dual_mode_enc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm       (pwm),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready),
  .cm_lvl    (cm_lvl),
  .dm_code   (dm_code)
);

// File: tb/sim_pam_dual_mode_enc.sv
`timescale 1ns/1ps
module sim_pam_dual_mode_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [2:0] sym_data = 3'd0;
  logic [1:0] cm_lvl;
  logic [2:0] dm_code;

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // model state
  logic       m_pwm_q;
  logic [1:0] m_cm;
  logic [2:0] m_dm;

  always #10 clk = ~clk;

  pam_dual_mode_enc u0 (
    .clk(clk), .rst_n(rst_n), .pwm(pwm), .sym_valid(sym_valid),
    .sym_ready(sym_ready), .sym_data(sym_data), .cm_lvl(cm_lvl), .dm_code(dm_code)
  );

  function automatic logic [1:0] exp_cm(input logic [2:0] d);
    case (d)
      3'b000, 3'b001:                 return 2'd2;
      3'b011, 3'b010, 3'b110, 3'b111: return 2'd1;
      default:                        return 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] exp_dm(input logic [2:0] d);
    case (d)
      3'b000:  return 3'b111;
      3'b001:  return 3'b001;
      3'b011:  return 3'b110;
      3'b010:  return 3'b111;
      3'b110:  return 3'b001;
      3'b111:  return 3'b010;
      3'b101:  return 3'b110;
      default: return 3'b010;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwm_q <= 1'b0; m_cm <= 2'd1; m_dm <= 3'd0;
    end else begin
      m_pwm_q <= pwm;
      if (pwm && !m_pwm_q) begin
        if (sym_valid) begin m_cm <= exp_cm(sym_data); m_dm <= exp_dm(sym_data); end
        else m_dm <= 3'd0;
      end else if (!pwm) m_dm <= 3'd0;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2", int'(sym_ready), int'(pwm && !m_pwm_q));
      chk("R6", int'(cm_lvl), int'(m_cm));
      chk(m_pwm_q ? "R4" : "R5", int'(dm_code), int'(m_dm));
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic symbol(input logic [2:0] d, input bit v, input int hi, input int lo, input bit noise);
    step(); pwm = 1'b1; sym_data = d; sym_valid = v;
    for (int i = 1; i < hi; i++) begin
      step();
      if (noise) begin sym_data = 3'($urandom); sym_valid = 1'($urandom); end
    end
    step(); pwm = 1'b0;
    for (int i = 0; i < lo; i++) begin
      if (noise) begin sym_data = 3'($urandom); sym_valid = 1'($urandom); end
      if (i + 1 < lo) step();
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    #15;
    chk("R1", int'(cm_lvl), 1);
    chk("R1", int'(dm_code), 0);
    chk("R1", int'(sym_ready), 0);
    step(); step(); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(cm_lvl), 1);
    chk("R1", int'(dm_code), 0);
    chk_on = 1'b1;

    // R3 / R8: full sweep, check the mapped pair directly
    for (int k = 0; k < 8; k++) begin
      step(); pwm = 1'b1; sym_data = 3'(k); sym_valid = 1'b1;
      @(negedge clk);
      chk("R2", int'(sym_ready), 1);
      step(); sym_valid = 1'b0;
      @(negedge clk);
      chk("R3", int'(cm_lvl), int'(exp_cm(3'(k))));
      chk("R3", int'(dm_code), int'(exp_dm(3'(k))));
      chk("R8", int'(dm_code == 3'b011 || dm_code == 3'b100 || dm_code == 3'b101), 0);
      step(); pwm = 1'b0;
    end

    // R9: data changes mid-symbol are ignored
    step(); pwm = 1'b1; sym_data = 3'b111; sym_valid = 1'b1;
    step(); sym_data = 3'b101;
    @(negedge clk);
    chk("R9", int'(dm_code), int'(exp_dm(3'b111)));
    step();
    @(negedge clk);
    chk("R9", int'(cm_lvl), 1);
    step(); pwm = 1'b0; sym_data = 3'b000;
    step(); step();
    @(negedge clk);
    chk("R9", int'(cm_lvl), 1);

    // R7: rising edge with no valid symbol
    step(); pwm = 1'b1; sym_valid = 1'b0; sym_data = 3'b000;
    step();
    @(negedge clk);
    chk("R7", int'(dm_code), 0);
    chk("R7", int'(cm_lvl), 1);
    step(); pwm = 1'b0;

    // minimal phases: one cycle high, one cycle low
    symbol(3'b000, 1'b1, 1, 1, 1'b0);
    symbol(3'b100, 1'b1, 1, 1, 1'b0);

    // constrained random
    for (int s = 0; s < 400; s++)
      symbol(3'($urandom), ($urandom % 5) != 0, 1 + int'($urandom % 4), 1 + int'($urandom % 4), 1'b1);

    step(); step();
    chk_on = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule